// File: doc/BRIEF.md
# Bit-Sliced Arithmetic Logic Unit with Operand Inversion

The block is a purely combinational arithmetic logic unit of parameterised width, 32 bits by default. It is built from identical one-bit slices. Each slice can complement its A bit and its B bit. A two-bit selector then chooses one of four things for the slice's result bit: the AND of the two bits, their OR, the full-adder sum, or a "less" input. The slices form a ripple-carry chain. The least significant slice takes its carry-in from the B-complement control, so subtraction is computed as A + ~B + 1.

A four-bit control word selects the function. Bit 3 complements A, bit 2 complements B, and bits 1:0 drive the slice selector. This gives six functions: and, or, nor, add, subtract and signed set-less-than. Set-less-than works as follows. The unit performs a subtraction, and the corrected sign of that subtraction is routed back into the "less" input of the bottom slice. The "less" inputs of all other slices are tied low.

Three flags accompany the result: zero, signed overflow and carry-out. A control word outside the six defined codes produces a zero result with every flag low.

Top module: `slice_alu`

## Requirements
- R1: Control 4'b0000 gives result = A & B.
- R2: Control 4'b0001 gives result = A | B.
- R3: Control 4'b1100 gives result = ~(A | B), built as the AND of both complemented operands.
- R4: Control 4'b0010 gives result = (A + B) mod 2^W. The carry flag equals bit W of the full sum.
- R5: Control 4'b0110 gives result = (A + ~B + 1) mod 2^W. The carry flag equals bit W of that sum, which is 1 exactly when A >= B unsigned.
- R6: For add and subtract, the overflow flag is 1 exactly when the sign bits of the two addends agree and the sign bit of the result differs from them. For subtract, the second addend is ~B.
- R7: Control 4'b0111 gives result bit 0 = 1 when A < B as two's-complement numbers, including when A - B overflows. Result bits W-1:1 are 0. The overflow and carry flags are those of the subtraction A - B.
- R8: For and, or and nor, the overflow and carry flags are 0.
- R9: For the six defined codes, the zero flag is 1 exactly when all W result bits are 0.
- R10: Any other control code gives result 0, zero flag 0, overflow flag 0 and carry flag 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | W | First operand |
| op_b | input | W | Second operand |
| alu_ctrl | input | 4 | {A complement, B complement, slice select[1:0]} |
| alu_result | output | W | Selected function result |
| flag_zero | output | 1 | Result is all zeros (defined codes only) |
| flag_ovf | output | 1 | Signed overflow of add, subtract or set-less-than |
| flag_carry | output | 1 | Carry out of the most significant slice |

## Verification
The block holds no state, so any internal fault appears at the ports in the same evaluation as the operands that expose it. A broken link in the carry chain corrupts every sum bit above the break, and it only shows for operands whose carries propagate that far. A wrong sign-correction path back into the bottom slice makes set-less-than give the wrong answer only when A - B overflows. The bench therefore sweeps every operand pair and every control code on a 4-bit instance, and it drives the overflow and sign-boundary corner operands on a 32-bit instance.

// File: rtl/slice_alu_pkg.sv
package slice_alu_pkg;

    typedef enum logic [3:0] {
        CTL_AND = 4'b0000,
        CTL_OR  = 4'b0001,
        CTL_ADD = 4'b0010,
        CTL_SUB = 4'b0110,
        CTL_SLT = 4'b0111,
        CTL_NOR = 4'b1100
    } alu_ctl_e;

    localparam logic [1:0] SEL_AND  = 2'b00;
    localparam logic [1:0] SEL_OR   = 2'b01;
    localparam logic [1:0] SEL_SUM  = 2'b10;
    localparam logic [1:0] SEL_LESS = 2'b11;

    typedef struct packed {
        logic zero;
        logic ovf;
        logic carry;
    } alu_flags_t;

    function automatic logic ctl_is_defined(input logic [3:0] c);
        return (c == CTL_AND) || (c == CTL_OR) || (c == CTL_ADD) ||
               (c == CTL_SUB) || (c == CTL_SLT) || (c == CTL_NOR);
    endfunction

endpackage

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
    import slice_alu_pkg::*;
(
    input  logic       a_bit,
    input  logic       b_bit,
    input  logic       a_inv,
    input  logic       b_inv,
    input  logic       carry_in,
    input  logic       less_in,
    input  logic [1:0] sel,
    output logic       res_bit,
    output logic       carry_out
);
    logic a_eff;
    logic b_eff;

    always_comb begin
        a_eff     = a_bit ^ a_inv;
        b_eff     = b_bit ^ b_inv;
        carry_out = (a_eff & b_eff) | (a_eff & carry_in) | (b_eff & carry_in);
        case (sel)
            SEL_AND: res_bit = a_eff & b_eff;
            SEL_OR:  res_bit = a_eff | b_eff;
            SEL_SUM: res_bit = a_eff ^ b_eff ^ carry_in;
            default: res_bit = less_in;
        endcase
    end
endmodule

// File: rtl/alu_msb_flags.sv
module alu_msb_flags (
    input  logic a_msb,
    input  logic b_msb,
    input  logic a_inv,
    input  logic b_inv,
    input  logic cin_msb,
    input  logic cout_msb,
    output logic ovf_raw,
    output logic carry_raw,
    output logic less_set
);
    logic a_eff;
    logic b_eff;
    logic sum_msb;

    always_comb begin
        a_eff     = a_msb ^ a_inv;
        b_eff     = b_msb ^ b_inv;
        sum_msb   = a_eff ^ b_eff ^ cin_msb;
        ovf_raw   = (a_eff == b_eff) && (sum_msb != a_eff);
        carry_raw = cout_msb;
        less_set  = sum_msb ^ ovf_raw;
    end
endmodule

// File: rtl/slice_alu.sv
module slice_alu
    import slice_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic [3:0]   alu_ctrl,
    output logic [W-1:0] alu_result,
    output logic         flag_zero,
    output logic         flag_ovf,
    output logic         flag_carry
);
    localparam int MSB = W - 1;

    logic       a_inv;
    logic       b_inv;
    logic [1:0] sel;
    logic       ctl_ok;
    logic       carry_c [W+1];
    logic       res_c   [W];
    logic       less_set;
    logic       ovf_raw;
    logic       carry_raw;

    logic [W-1:0] result_d;
    alu_flags_t   flags_d;

    always_comb begin
        a_inv  = alu_ctrl[3];
        b_inv  = alu_ctrl[2];
        sel    = alu_ctrl[1:0];
        ctl_ok = ctl_is_defined(alu_ctrl);
    end

    assign carry_c[0] = b_inv;

    for (genvar i = 0; i < W; i++) begin : g_slice
        logic less_i;
        if (i == 0) begin : g_lsb
            assign less_i = less_set;
        end else begin : g_upper
            assign less_i = 1'b0;
        end
        alu_bit_slice slice_i (
            .a_bit    (op_a[i]),
            .b_bit    (op_b[i]),
            .a_inv    (a_inv),
            .b_inv    (b_inv),
            .carry_in (carry_c[i]),
            .less_in  (less_i),
            .sel      (sel),
            .res_bit  (res_c[i]),
            .carry_out(carry_c[i+1])
        );
    end

    alu_msb_flags msb_flags_i (
        .a_msb    (op_a[MSB]),
        .b_msb    (op_b[MSB]),
        .a_inv    (a_inv),
        .b_inv    (b_inv),
        .cin_msb  (carry_c[MSB]),
        .cout_msb (carry_c[W]),
        .ovf_raw  (ovf_raw),
        .carry_raw(carry_raw),
        .less_set (less_set)
    );

    always_comb begin
        result_d = '0;
        flags_d  = '0;
        if (ctl_ok) begin
            for (int k = 0; k < W; k++) begin
                result_d[k] = res_c[k];
            end
            flags_d.zero  = (result_d == '0);
            flags_d.ovf   = sel[1] & ovf_raw;
            flags_d.carry = sel[1] & carry_raw;
        end
    end

    assign alu_result = result_d;
    assign flag_zero  = flags_d.zero;
    assign flag_ovf   = flags_d.ovf;
    assign flag_carry = flags_d.carry;
endmodule

// File: rtl/slice_alu_chk.sv
module slice_alu_chk #(
    parameter int W = 32
) (
    input logic [W-1:0] op_a,
    input logic [W-1:0] op_b,
    input logic [3:0]   alu_ctrl,
    input logic [W-1:0] alu_result,
    input logic         flag_zero,
    input logic         flag_ovf,
    input logic         flag_carry
);
    localparam int M = W - 1;

    logic is_logic_op;
    logic is_defined;

    always_comb begin
        is_logic_op = (alu_ctrl == 4'b0000) || (alu_ctrl == 4'b0001) ||
                      (alu_ctrl == 4'b1100);
        is_defined  = is_logic_op || (alu_ctrl == 4'b0010) ||
                      (alu_ctrl == 4'b0110) || (alu_ctrl == 4'b0111);

        if (is_logic_op) begin
            assert_logic_flags_low_R8: assert (!flag_ovf && !flag_carry);
        end
        if (!is_defined) begin
            assert_undefined_quiet_R10: assert (alu_result == '0 && !flag_zero &&
                                               !flag_ovf && !flag_carry);
        end
        if (is_defined) begin
            assert_zero_flag_R9: assert (flag_zero == (alu_result == '0));
        end
        if (alu_ctrl == 4'b0010) begin
            assert_add_overflow_R6: assert (flag_ovf ==
                ((op_a[M] == op_b[M]) && (alu_result[M] != op_a[M])));
        end
        if (alu_ctrl == 4'b0111) begin
            assert_slt_upper_clear_R7: assert (alu_result[M:1] == '0);
        end
    end
endmodule

bind slice_alu slice_alu_chk #(.W(W)) chk_i (
    .op_a      (op_a),
    .op_b      (op_b),
    .alu_ctrl  (alu_ctrl),
    .alu_result(alu_result),
    .flag_zero (flag_zero),
    .flag_ovf  (flag_ovf),
    .flag_carry(flag_carry)
);

// File: tb/slice_alu_tb_top.sv
`timescale 1ns/1ps
module slice_alu_tb_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    logic [3:0]  sa, sb;
    logic [3:0]  sc;
    logic [3:0]  sr;
    logic        sz, so, scy;

    logic [31:0] wa, wb;
    logic [3:0]  wc;
    logic [31:0] wr;
    logic        wz, wo, wcy;

    slice_alu #(.W(4)) dut_i (
        .op_a(sa), .op_b(sb), .alu_ctrl(sc), .alu_result(sr),
        .flag_zero(sz), .flag_ovf(so), .flag_carry(scy)
    );

    slice_alu #(.W(32)) dut_w_i (
        .op_a(wa), .op_b(wb), .alu_ctrl(wc), .alu_result(wr),
        .flag_zero(wz), .flag_ovf(wo), .flag_carry(wcy)
    );

    function automatic string res_tag(input logic [3:0] c);
        case (c)
            4'b0000: return "R1";
            4'b0001: return "R2";
            4'b1100: return "R3";
            4'b0010: return "R4";
            4'b0110: return "R5";
            4'b0111: return "R7";
            default: return "R10";
        endcase
    endfunction

    function automatic string flag_tag(input logic [3:0] c);
        case (c)
            4'b0000, 4'b0001, 4'b1100: return "R8";
            4'b0010, 4'b0110, 4'b0111: return "R6";
            default: return "R10";
        endcase
    endfunction

    task automatic model(input int n, input logic [63:0] a, input logic [63:0] b,
                         input logic [3:0] c, output logic [63:0] r,
                         output logic z, output logic o, output logic cy);
        logic [63:0] mask, s, bn;
        longint sa_l, sb_l;
        bit defined;
        mask = (64'd1 << n) - 64'd1;
        r = 0; o = 0; cy = 0; defined = 1'b1;
        bn = ~b & mask;
        case (c)
            4'b0000: r = a & b;
            4'b0001: r = a | b;
            4'b1100: r = ~(a | b) & mask;
            4'b0010: begin
                s = a + b; r = s & mask; cy = s[n];
                o = (a[n-1] == b[n-1]) && (s[n-1] != a[n-1]);
            end
            4'b0110, 4'b0111: begin
                s = a + bn + 64'd1; r = s & mask; cy = s[n];
                o = (a[n-1] == bn[n-1]) && (s[n-1] != a[n-1]);
                if (c == 4'b0111) begin
                    sa_l = longint'(a); sb_l = longint'(b);
                    if (a[n-1]) sa_l = sa_l - (longint'(1) << n);
                    if (b[n-1]) sb_l = sb_l - (longint'(1) << n);
                    r = (sa_l < sb_l) ? 64'd1 : 64'd0;
                end
            end
            default: defined = 1'b0;
        endcase
        z = defined && (r == 0);
    endtask

    task automatic cmp(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input int n, input logic [63:0] a, input logic [63:0] b,
                             input logic [3:0] c, input logic [63:0] r,
                             input logic z, input logic o, input logic cy);
        logic [63:0] er;
        logic ez, eo, ecy;
        model(n, a, b, c, er, ez, eo, ecy);
        cmp(res_tag(c), "result", r, er);
        cmp((c == 4'b0000 || c == 4'b0001 || c == 4'b1100 || c == 4'b0010 ||
             c == 4'b0110 || c == 4'b0111) ? "R9" : "R10", "zero", {63'd0, z}, {63'd0, ez});
        cmp(flag_tag(c), "ovf", {63'd0, o}, {63'd0, eo});
        cmp((c == 4'b0010) ? "R4" : (c == 4'b0110) ? "R5" : (c == 4'b0111) ? "R7" :
            flag_tag(c), "carry", {63'd0, cy}, {63'd0, ecy});
    endtask

    task automatic apply_w(input logic [31:0] a, input logic [31:0] b, input logic [3:0] c);
        @(posedge clk);
        wa = a; wb = b; wc = c;
        @(negedge clk);
        check_all(32, {32'd0, a}, {32'd0, b}, c, {32'd0, wr}, wz, wo, wcy);
    endtask

    initial begin
        sa = '0; sb = '0; sc = '0;
        wa = '0; wb = '0; wc = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // Initial idle inputs: and of zeros gives zero result with zero flag set (R1, R9)
        check_all(32, 64'd0, 64'd0, 4'b0000, {32'd0, wr}, wz, wo, wcy);

        // Exhaustive sweep on the 4-bit instance: R1..R10 every code, every pair
        for (int c = 0; c < 16; c++) begin
            for (int a = 0; a < 16; a++) begin
                for (int b = 0; b < 16; b++) begin
                    @(posedge clk);
                    sa = 4'(a); sb = 4'(b); sc = 4'(c);
                    @(negedge clk);
                    check_all(4, 64'(a), 64'(b), 4'(c), {60'd0, sr}, sz, so, scy);
                end
            end
        end

        // 32-bit corners: R6 signed overflow on add and subtract
        apply_w(32'h7FFF_FFFF, 32'h0000_0001, 4'b0010);
        apply_w(32'h8000_0000, 32'h0000_0001, 4'b0110);
        apply_w(32'hFFFF_FFFF, 32'h0000_0001, 4'b0010);   // R4 carry, zero result R9
        apply_w(32'h1234_5678, 32'h1234_5678, 4'b0110);   // R5 equal operands
        // R7 set-less-than with overflowing difference
        apply_w(32'h8000_0000, 32'h7FFF_FFFF, 4'b0111);
        apply_w(32'h7FFF_FFFF, 32'h8000_0000, 4'b0111);
        apply_w(32'h1234_5678, 32'h1234_5678, 4'b0111);
        apply_w(32'hFFFF_FFFF, 32'h0000_0000, 4'b0111);
        apply_w(32'hF0F0_F0F0, 32'h0FF0_0FF0, 4'b1100);   // R3
        apply_w(32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'b1011);   // R10
        for (int k = 0; k < 6; k++) begin
            for (int j = 0; j < 300; j++) begin
                logic [3:0] cc;
                case (k)
                    0: cc = 4'b0000; 1: cc = 4'b0001; 2: cc = 4'b0010;
                    3: cc = 4'b0110; 4: cc = 4'b0111; default: cc = 4'b1100;
                endcase
                apply_w($urandom, $urandom, cc);
            end
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule